// File: doc/BRIEF.md
# Display Control Register Decoder

This block takes 32-bit control words from a host write port and turns them into display state. The top byte of each word is a command number and the lower bits are its arguments. The block keeps a shadow copy of the most recent word for each low-numbered command. It maintains a packed status word and tracks the display origin, the horizontal range (measured in clock units) and the vertical range (in lines). It also tracks the horizontal and vertical resolution, and from these it derives the visible screen width and height.

A second port loads the drawing-environment words. Info-query commands read these back through a read-back word. Commands 0 and 1 send a one-cycle reset pulse to the command and transfer logic downstream.

The visible width is the horizontal range scaled by the resolution and divided by 2560. A serial divider computes it while `busy` is high, and any control write presented during that time is dropped.

The geometry sequencer has three states:
- `ST_IDLE`: waits for an accepted write to command 6, 7 or 8, then goes to `ST_RECALC`.
- `ST_RECALC`: loads the new height. If the range covers the full width it also loads the width and returns to `ST_IDLE`. Otherwise it starts the divider and goes to `ST_DIVIDE`.
- `ST_DIVIDE`: waits for the divider's done pulse, loads the width and returns to `ST_IDLE`.

Top module: `disp_ctrl_decoder`

## Requirements
- R1: After an active-low `rst_n`, and after an accepted command 0, the outputs take these values: `status_word` = 0x14802000, `rd_word` = 0, `hres` = `scr_w` = 256, `vres` = `scr_h` = 240. Every environment slot i holds (0xE0+i)<<24, and the shadow of command 3 holds 1 while all other shadows hold 0.
- R2: A write is ignored when its command is below 16, above 1, not 5, and its word equals the stored shadow for that command. An ignored write does not raise `busy`.
- R3: An accepted command 0 or command 1 drives `path_reset` high for exactly the one cycle after the write edge.
- R4: Command 3 copies data[0] into status bit 23 (blanking). Command 4 copies data[1:0] into status bits [30:29] (transfer direction).
- R5: Command 5 sets `disp_x` = data[9:0] and `disp_y` = data[19:10].
- R6: Command 6 sets the horizontal range start to data[11:0] and its end to data[23:12]. If d = end − start is ≤ 0 or ≥ 2560, the width equals `hres`. Otherwise the width is floor(d·hres/2560).
- R7: Command 7 sets the vertical range start to data[9:0] and its end to data[19:10]. The height is end − start, doubled when status bit 19 is set, and replaced by `vres` when the result is ≤ 0.
- R8: Command 8 writes data[5:0] to status[22:17] and data[6] to status[16]. It then sets `hres` from status[18:16] through {256,368,320,384,512,512,640,640} and `vres` from status[20:19] through {240,480,256,480}, and recomputes width and height.
- R9: Commands 0x10–0x1F answer on data[3:0] through `rd_word`. Codes 2–5 return environment slot (code&7) masked to 20 bits, code 6 returns slot 5 masked to 20 bits, code 7 returns 2, and any other code returns 0. `rd_word[31:20]` is always 0.
- R10: A word on the environment port whose bits [31:27] are 11100 is stored into slot data[26:24] and is seen by later queries.
- R11: While `busy` is high, control writes are dropped and the status word does not change. Whenever `busy` is low, `scr_w` ≤ `hres` and `scr_h` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word valid |
| wr_data | input | 32 | Control word, command in [31:24] |
| env_we | input | 1 | Environment word valid |
| env_data | input | 32 | Environment word, slot tag in [31:24] |
| busy | output | 1 | Geometry recomputation in progress |
| status_word | output | 32 | Packed status register |
| rd_word | output | 32 | Answer to the last info query |
| disp_x | output | 10 | Display origin x |
| disp_y | output | 10 | Display origin y |
| hres | output | 10 | Horizontal resolution |
| vres | output | 10 | Vertical resolution |
| scr_w | output | 12 | Visible width |
| scr_h | output | 12 | Visible height |
| path_reset | output | 1 | One-cycle reset to command/transfer logic |

## Verification
A wrong shadow value shows up on the next identical write. A redundant write that is wrongly accepted raises `busy` one cycle after the edge, and a valid write that is wrongly suppressed leaves it low. A wrong range or resolution register shows up in `scr_w` or `scr_h` once `busy` falls, which is about two dozen cycles after the write for the divided width and two cycles for the full-width or height-only case. A corrupted environment slot stays hidden until a query for it lands in `rd_word` one cycle after the query write.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECALC = 2'd1,
        ST_DIVIDE = 2'd2
    } geom_state_e;

    localparam logic [31:0] STATUS_INIT = 32'h1480_2000;
    localparam int BLANK_BIT   = 23;
    localparam int DHEIGHT_BIT = 19;
    localparam int DIR_LO      = 29;
    localparam int MODE_LO     = 16;

    function automatic logic [9:0] hres_of(input logic [2:0] idx);
        logic [9:0] r;
        unique case (idx)
            3'd0: r = 10'd256;
            3'd1: r = 10'd368;
            3'd2: r = 10'd320;
            3'd3: r = 10'd384;
            3'd4, 3'd5: r = 10'd512;
            default: r = 10'd640;
        endcase
        return r;
    endfunction

    function automatic logic [9:0] vres_of(input logic [1:0] idx);
        logic [9:0] r;
        unique case (idx)
            2'd0: r = 10'd240;
            2'd2: r = 10'd256;
            default: r = 10'd480;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/disp_scale_div.sv
module disp_scale_div #(
    parameter int PW = 22,
    parameter int DW = 12,
    parameter int QW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient
);
    localparam int CW = $clog2(PW + 1);

    logic [CW-1:0] count_q;
    logic          run_q;
    logic [DW:0]   rem_q;
    logic [PW-1:0] dvd_q;
    logic [PW-1:0] quo_q;
    logic [DW:0]   rem_sh;
    logic          fits;

    assign rem_sh = {rem_q[DW-1:0], dvd_q[PW-1]};
    assign fits   = rem_sh >= {1'b0, divisor};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
            rem_q   <= '0;
            dvd_q   <= '0;
            quo_q   <= '0;
            done    <= 1'b0;
        end else if (start) begin
            count_q <= CW'(PW);
            run_q   <= 1'b1;
            rem_q   <= '0;
            dvd_q   <= dividend;
            quo_q   <= '0;
            done    <= 1'b0;
        end else if (run_q) begin
            rem_q   <= fits ? (rem_sh - {1'b0, divisor}) : rem_sh;
            quo_q   <= {quo_q[PW-2:0], fits};
            dvd_q   <= {dvd_q[PW-2:0], 1'b0};
            count_q <= count_q - 1'b1;
            if (count_q == CW'(1)) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo_q[QW-1:0];

    // R6: the scaled width never needs more bits than the result port
    p_quot_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quo_q[PW-1:QW] == '0));

    // R11: a fresh start cannot report completion on the next cycle
    p_start_not_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

endmodule

// File: rtl/disp_env_bank.sv
module disp_env_bank #(
    parameter int N_ENV = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   we,
    input  logic [31:0]            wdata,
    output logic [N_ENV-1:0][31:0] slots
);
    localparam int IDX_W = $clog2(N_ENV);
    localparam logic [7:0] TAG_BASE = 8'hE0;

    logic             tag_ok;
    logic [IDX_W-1:0] widx;

    assign tag_ok = (wdata[31:24] >> IDX_W) == (TAG_BASE >> IDX_W);
    assign widx   = wdata[24 +: IDX_W];

    for (genvar i = 0; i < N_ENV; i++) begin : g_slot
        localparam logic [7:0] INIT_TAG = 8'(224 + i);
        logic [31:0] slot_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                slot_q <= {INIT_TAG, 24'h0};
            end else if (we && tag_ok && widx == IDX_W'(i)) begin
                slot_q <= wdata;
            end
        end

        assign slots[i] = slot_q;
    end

endmodule

// File: rtl/disp_info_query.sv
module disp_info_query #(
    parameter int N_ENV = 8
) (
    input  logic [3:0]             code,
    input  logic [N_ENV-1:0][31:0] slots,
    output logic [31:0]            answer
);
    localparam logic [31:0] LOW20 = 32'h000F_FFFF;

    always_comb begin
        unique case (code)
            4'd2, 4'd3, 4'd4, 4'd5: answer = slots[code[2:0]] & LOW20;
            4'd6:                   answer = slots[5] & LOW20;
            4'd7:                   answer = 32'd2;
            default:                answer = 32'd0;
        endcase
    end

endmodule

// File: rtl/disp_ctrl_decoder.sv
module disp_ctrl_decoder
    import disp_ctrl_pkg::*;
#(
    parameter int SHADOW_DEPTH = 16,
    parameter int N_ENV        = 8,
    parameter int SPAN         = 2560,
    parameter int X_W          = 12,
    parameter int Y_W          = 10,
    parameter int RES_W        = 10,
    parameter int GEOM_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              env_we,
    input  logic [31:0]       env_data,
    output logic              busy,
    output logic [31:0]       status_word,
    output logic [31:0]       rd_word,
    output logic [9:0]        disp_x,
    output logic [9:0]        disp_y,
    output logic [RES_W-1:0]  hres,
    output logic [RES_W-1:0]  vres,
    output logic [GEOM_W-1:0] scr_w,
    output logic [GEOM_W-1:0] scr_h,
    output logic              path_reset
);
    localparam int SIDX_W = $clog2(SHADOW_DEPTH);
    localparam int PW     = X_W + RES_W;
    localparam int SPAN_W = $clog2(SPAN + 1);
    localparam int HS_W   = Y_W + 3;
    localparam logic [RES_W-1:0] H_INIT = RES_W'(hres_of(3'd0));
    localparam logic [RES_W-1:0] V_INIT = RES_W'(vres_of(2'd0));

    // ---------------- command decode ----------------
    logic [7:0]  cmd;
    logic        in_shadow, redundant, accept, full_reset, is_query;
    logic [31:0] shadow_q [SHADOW_DEPTH];

    assign cmd        = wr_data[31:24];
    assign in_shadow  = 32'(cmd) < SHADOW_DEPTH;
    assign redundant  = in_shadow && (cmd > 8'd1) && (cmd != 8'd5)
                        && (shadow_q[cmd[SIDX_W-1:0]] == wr_data);
    assign accept     = wr_en && !busy && !redundant;
    assign full_reset = accept && (cmd == 8'd0);
    assign is_query   = cmd[7:4] == 4'h1;

    always_ff @(posedge clk) begin
        if (!rst_n || full_reset) begin
            for (int i = 0; i < SHADOW_DEPTH; i++) begin
                shadow_q[i] <= (i == 3) ? 32'd1 : 32'd0;
            end
        end else if (accept && in_shadow) begin
            shadow_q[cmd[SIDX_W-1:0]] <= wr_data;
        end
    end

    // ---------------- environment slots and queries ----------------
    logic [N_ENV-1:0][31:0] env_slots;
    logic [31:0]            query_ans;

    disp_env_bank #(.N_ENV(N_ENV)) u_env (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (full_reset),
        .we    (env_we),
        .wdata (env_data),
        .slots (env_slots)
    );

    disp_info_query #(.N_ENV(N_ENV)) u_query (
        .code   (wr_data[3:0]),
        .slots  (env_slots),
        .answer (query_ans)
    );

    // ---------------- status, resolution, read-back, pulse ----------------
    logic [31:0]      status_q, rd_q;
    logic [RES_W-1:0] hres_q, vres_q;
    logic             pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n || full_reset) begin
            status_q <= STATUS_INIT;
            hres_q   <= H_INIT;
            vres_q   <= V_INIT;
            rd_q     <= '0;
        end else if (accept) begin
            unique case (cmd)
                8'h03: status_q[BLANK_BIT] <= wr_data[0];
                8'h04: status_q[DIR_LO +: 2] <= wr_data[1:0];
                8'h08: begin
                    status_q[MODE_LO +: 7] <= {wr_data[5:0], wr_data[6]};
                    hres_q <= RES_W'(hres_of({wr_data[1:0], wr_data[6]}));
                    vres_q <= RES_W'(vres_of(wr_data[3:2]));
                end
                default: begin
                    if (is_query) rd_q <= query_ans;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= accept && (cmd <= 8'd1);
    end

    // ---------------- origin and ranges ----------------
    logic [9:0]     org_x_q, org_y_q;
    logic [X_W-1:0] x1_q, x2_q;
    logic [Y_W-1:0] y1_q, y2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            org_x_q <= '0;
            org_y_q <= '0;
            x1_q    <= '0;
            x2_q    <= '0;
            y1_q    <= '0;
            y2_q    <= '0;
        end else if (accept) begin
            if (cmd == 8'h05) begin
                org_x_q <= wr_data[9:0];
                org_y_q <= wr_data[19:10];
            end
            if (cmd == 8'h06) begin
                x1_q <= wr_data[X_W-1:0];
                x2_q <= wr_data[2*X_W-1:X_W];
            end
            if (cmd == 8'h07) begin
                y1_q <= wr_data[Y_W-1:0];
                y2_q <= wr_data[2*Y_W-1:Y_W];
            end
        end
    end

    // ---------------- geometry arithmetic ----------------
    logic signed [X_W:0]  span_x;
    logic                 full_w;
    logic [PW-1:0]        prod;
    logic signed [HS_W-1:0] span_y_base, span_y;
    logic [GEOM_W-1:0]    h_next;

    assign span_x = $signed({1'b0, x2_q}) - $signed({1'b0, x1_q});
    assign full_w = (span_x <= 0) || (span_x >= $signed((X_W+1)'(SPAN)));
    assign prod   = PW'(x2_q - x1_q) * PW'(hres_q);

    assign span_y_base = $signed({3'b000, y2_q}) - $signed({3'b000, y1_q});
    assign span_y      = status_q[DHEIGHT_BIT] ? (span_y_base <<< 1) : span_y_base;
    assign h_next      = (span_y <= 0) ? GEOM_W'(vres_q) : GEOM_W'(span_y);

    // ---------------- geometry sequencer ----------------
    geom_state_e      state_q, state_d;
    logic             div_start, div_done;
    logic [RES_W-1:0] div_quot;
    logic [GEOM_W-1:0] w_q, h_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && (cmd == 8'h06 || cmd == 8'h07 || cmd == 8'h08))
                    state_d = ST_RECALC;
            end
            ST_RECALC: state_d = full_w ? ST_IDLE : ST_DIVIDE;
            ST_DIVIDE: begin
                if (div_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign div_start = (state_q == ST_RECALC) && !full_w;

    always_ff @(posedge clk) begin
        if (!rst_n || full_reset) begin
            w_q <= GEOM_W'(H_INIT);
            h_q <= GEOM_W'(V_INIT);
        end else if (state_q == ST_RECALC) begin
            h_q <= h_next;
            if (full_w) w_q <= GEOM_W'(hres_q);
        end else if (state_q == ST_DIVIDE && div_done) begin
            w_q <= GEOM_W'(div_quot);
        end
    end

    disp_scale_div #(.PW(PW), .DW(SPAN_W), .QW(RES_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (prod),
        .divisor  (SPAN_W'(SPAN)),
        .done     (div_done),
        .quotient (div_quot)
    );

    // ---------------- outputs ----------------
    assign busy        = state_q != ST_IDLE;
    assign status_word = status_q;
    assign rd_word     = rd_q;
    assign disp_x      = org_x_q;
    assign disp_y      = org_y_q;
    assign hres        = hres_q;
    assign vres        = vres_q;
    assign scr_w       = w_q;
    assign scr_h       = h_q;
    assign path_reset  = pulse_q;

    // ---------------- assertions ----------------
    // R3: a pulse only follows an accepted command 0 or 1
    p_pulse_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        path_reset |-> ($past(wr_en) && !$past(busy) && ($past(wr_data[31:24]) <= 8'd1)));

    // R6: when settled, the visible width never exceeds the resolution
    p_width_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scr_w <= GEOM_W'(hres)));

    // R7: when settled, the height is never zero
    p_height_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scr_h != '0));

    // R9: read-back answers are at most 20 bits wide
    p_rd_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[31:20] == 12'h000);

    // R11: a write presented while busy leaves the status untouched
    p_drop_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(status_word));

endmodule

// File: tb/disp_ctrl_decoder_bench.sv
module disp_ctrl_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic [31:0] word;
        logic [31:0] st;
        logic [11:0] w;
        logic [11:0] h;
        logic [31:0] rd;
    } vec_t;

    // Cumulative sequence: each word is written, the bench waits for busy low, then compares.
    localparam vec_t VECS [NVEC] = '{
        '{32'h0300_0000, 32'h1400_2000, 12'd256, 12'd240, 32'd0},
        '{32'h0400_0002, 32'h5400_2000, 12'd256, 12'd240, 32'd0},
        '{32'h0500_C864, 32'h5400_2000, 12'd256, 12'd240, 32'd0},
        '{32'h06C6_0260, 32'h5400_2000, 12'd256, 12'd240, 32'd0},
        '{32'h06A3_0260, 32'h5400_2000, 12'd200, 12'd240, 32'd0},
        '{32'h0704_0010, 32'h5400_2000, 12'd200, 12'd240, 32'd0},
        '{32'h0700_C864, 32'h5400_2000, 12'd200, 12'd240, 32'd0},
        '{32'h0800_0001, 32'h5402_2000, 12'd250, 12'd240, 32'd0},
        '{32'h0800_0044, 32'h5409_2000, 12'd287, 12'd480, 32'd0},
        '{32'h0703_6010, 32'h5409_2000, 12'd287, 12'd400, 32'd0},
        '{32'h0610_0100, 32'h5409_2000, 12'd368, 12'd400, 32'd0},
        '{32'h0610_0200, 32'h5409_2000, 12'd368, 12'd400, 32'd0},
        '{32'h069F_F000, 32'h5409_2000, 12'd367, 12'd400, 32'd0},
        '{32'h1000_0007, 32'h5409_2000, 12'd367, 12'd400, 32'd2},
        '{32'h1000_0003, 32'h5409_2000, 12'd367, 12'd400, 32'd0},
        '{32'h1000_000A, 32'h5409_2000, 12'd367, 12'd400, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        env_we = 1'b0;
    logic [31:0] env_data = '0;
    logic        busy, path_reset;
    logic [31:0] status_word, rd_word;
    logic [9:0]  disp_x, disp_y, hres, vres;
    logic [11:0] scr_w, scr_h;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_ctrl_decoder u_disp_ctrl_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .env_we(env_we), .env_data(env_data), .busy(busy),
        .status_word(status_word), .rd_word(rd_word), .disp_x(disp_x),
        .disp_y(disp_y), .hres(hres), .vres(vres), .scr_w(scr_w),
        .scr_h(scr_h), .path_reset(path_reset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] word);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = word;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic env_wr(input logic [31:0] word);
        @(negedge clk);
        env_we   = 1'b1;
        env_data = word;
        @(negedge clk);
        env_we   = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 status", status_word, 32'h1480_2000);
        check("R1 rd", rd_word, 32'd0);
        check("R1 width", 32'(scr_w), 32'd256);
        check("R1 height", 32'(scr_h), 32'd240);
        check("R1 res", {6'd0, hres, 6'd0, vres}, {6'd0, 10'd256, 6'd0, 10'd240});
        check("R11 idle after reset", 32'(busy), 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            wr(VECS[k].word);
            wait_idle();
            check("table status (R4 R8)", status_word, VECS[k].st);
            check("table width (R6)", 32'(scr_w), 32'(VECS[k].w));
            check("table height (R7)", 32'(scr_h), 32'(VECS[k].h));
            check("table readback (R9)", rd_word, VECS[k].rd);
        end

        // R5: origin from vector 3
        check("R5 origin", {6'd0, disp_x, 6'd0, disp_y}, {6'd0, 10'd100, 6'd0, 10'd50});
        // R8: resolution after mode 0x44
        check("R8 res", {6'd0, hres, 6'd0, vres}, {6'd0, 10'd368, 6'd0, 10'd480});

        // R2: identical command 6 word is suppressed, busy stays low
        wr(32'h069F_F000);
        check("R2 redundant no busy", 32'(busy), 32'd0);
        wr(32'h069F_F001);
        check("R2 changed word busy", 32'(busy), 32'd1);
        wait_idle();
        check("R6 width 2558", 32'(scr_w), 32'd367);

        // R11: write during busy is dropped
        wr(32'h06A3_0260);
        check("R11 busy set", 32'(busy), 32'd1);
        wr_en = 1'b1;
        wr_data = 32'h0300_0001;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        check("R11 dropped status", status_word, 32'h5409_2000);
        check("R6 width 2000x368", 32'(scr_w), 32'd287);

        // R3: command 1 pulse
        wr(32'h0100_0000);
        check("R3 pulse high", 32'(path_reset), 32'd1);
        @(negedge clk);
        check("R3 pulse low", 32'(path_reset), 32'd0);

        // R10 / R9: environment slots through queries
        env_wr(32'hE301_2345);
        wr(32'h1000_0003);
        check("R10 slot3", rd_word, 32'h0001_2345);
        env_wr(32'hE5AB_CDEF);
        wr(32'h1000_0006);
        check("R9 code6 slot5", rd_word, 32'h000B_CDEF);
        wr(32'h1000_0005);
        check("R9 code5", rd_word, 32'h000B_CDEF);
        env_wr(32'hE2FF_FFFF);
        wr(32'h1000_0002);
        check("R9 code2 mask", rd_word, 32'h000F_FFFF);
        env_wr(32'hD4FF_FFFF);
        wr(32'h1000_0004);
        check("R10 bad tag ignored", rd_word, 32'd0);

        // R1: command 0 full reset
        wr(32'h1000_0007);
        wr(32'h0000_0000);
        check("R3 cmd0 pulse", 32'(path_reset), 32'd1);
        check("R1 cmd0 status", status_word, 32'h1480_2000);
        check("R1 cmd0 rd", rd_word, 32'd0);
        check("R1 cmd0 geom", {4'd0, scr_w, 4'd0, scr_h}, {4'd0, 12'd256, 4'd0, 12'd240});
        check("R1 cmd0 res", {6'd0, hres, 6'd0, vres}, {6'd0, 10'd256, 6'd0, 10'd240});
        wr(32'h1000_0003);
        check("R1 cmd0 env cleared", rd_word, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule